// File: doc/BRIEF.md
# Fractional Divider Port Controller

This block holds the control and status state for a multi-port fractional clock divider. Each output port divides the input clock by 2 × (I + F/36). I is the integer part of the port's divider word and F is the fractional part in steps of 1/36. The actual clock synthesis sits elsewhere. This block keeps the register state that software uses to program the ports. It sequences each port through hold, reprogramming and lock, and it records every loss of lock in a sticky flag.

One global hold bit keeps the whole divider quiet, so all ports can be programmed before it is released. Each port also has its own hold bit. When a port is out of both holds and holds a legal divider word, a per-port counter models lock acquisition. The port reports ready once the counter reaches the lock time. Changing a running port's divider restarts lock and flags a loss. Rewriting a locked port with the value it already holds changes nothing.

Top module: `fdiv_port_ctrl`

## Requirements
- R1: After reset the registers read as follows. The word addresses are 0 control (bit 0 is the global hold), 1 port hold (bit p for port p), 2 ready status, 3 loss flags, and 4+p the divider word of port p. Control reads 1, port hold reads all ones, ready reads 0 and loss reads 0. Each divider word reads with integer 1 and fraction 0.
- R2: While the global hold is 1, every ready bit reads 0, whatever the port hold bits are, and no port advances its lock counter.
- R3: A port with a legal divider reports ready exactly LOCK_CYCLES clock edges after the edge on which its last hold was released, and not earlier.
- R4: Setting a port's hold bit drops that port's ready bit on the next cycle. The other ports are not affected.
- R5: A write to the loss register clears exactly the flags whose mask bits are 1 and leaves the others set.
- R6: A loss flag stays set until it is cleared by a write, including after its port has locked again.
- R7: Writing a different divider word to a port that is out of hold sets that port's loss flag and drops its ready bit on the next cycle. It then restarts lock, and ready returns LOCK_CYCLES edges after the write.
- R8: A divider word whose integer part is 0 or whose fraction exceeds 35 is illegal. A port holding one never reports ready, and while it is out of hold its loss flag is set.
- R9: Writing a port's current divider word again while that port is ready with a clear loss flag has no effect: ready stays 1 and the loss flag stays 0.
- R10: A divider word holds the fraction in bits 5:0 and the integer in the bits from 6 upward, and reads back as written. A write to a port that is in hold sets no loss flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| port_ready | output | NUM_PORTS | Per-port locked and ready |
| port_lol | output | NUM_PORTS | Per-port sticky loss-of-lock flags |

## Verification
Some rules are checked on every cycle by the assertions. The global hold masks every ready bit. A loss flag stays set unless a clear write hits it. An illegal or changed divider on a running port raises its flag and drops ready on the next cycle. A same-value rewrite of a locked port leaves it ready and clean. Only the bench's scenarios can show the exact lock latency after a release, and that one port's hold leaves its neighbours alone. The same holds for the selective clear by mask, the register map and readback, and the full walk through legal and illegal divider words.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Fraction field width and number of fractional steps per integer unit
    localparam int FRAC_W     = 6;
    localparam int FRAC_STEPS = 36;

    // Register word addresses
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_HOLD  = 1;
    localparam int ADDR_READY = 2;
    localparam int ADDR_LOSS  = 3;
    localparam int ADDR_DIV0  = 4;

    // A divider word is legal when the integer part is non-zero and
    // the fraction stays below one full step count.
    function automatic logic div_legal(input logic int_nonzero,
                                       input logic [FRAC_W-1:0] frac);
        return int_nonzero && (int'(frac) < FRAC_STEPS);
    endfunction

endpackage

// File: rtl/fdiv_global_regs.sv
module fdiv_global_regs #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_wr,
    input  logic                 hold_wr,
    input  logic                 ctrl_bit,
    input  logic [NUM_PORTS-1:0] hold_bits,
    output logic                 glob_hold,
    output logic [NUM_PORTS-1:0] port_hold
);

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_hold <= 1'b1;
            port_hold <= '1;
        end else begin
            if (ctrl_wr) glob_hold <= ctrl_bit;
            if (hold_wr) port_hold <= hold_bits;
        end
    end

endmodule

// File: rtl/fdiv_port_unit.sv
module fdiv_port_unit
    import fdiv_pkg::*;
#(
    parameter int INT_W       = 8,
    parameter int LOCK_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              glob_hold,
    input  logic              port_hold,
    input  logic              div_wr,
    input  logic [INT_W-1:0]  wr_int,
    input  logic [FRAC_W-1:0] wr_frac,
    input  logic              loss_clr,
    output logic [INT_W-1:0]  div_int,
    output logic [FRAC_W-1:0] div_frac,
    output logic              ready,
    output logic              loss
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(LOCK_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic active, legal, same_val, filtered_wr, eff_wr, loss_set;

    assign active      = !glob_hold && !port_hold;
    assign legal       = div_legal(div_int != '0, div_frac);
    assign same_val    = (wr_int == div_int) && (wr_frac == div_frac);
    // a rewrite of the held value on a clean, locked port is dropped
    assign filtered_wr = div_wr && same_val && ready && !loss;
    assign eff_wr      = div_wr && !filtered_wr;
    assign loss_set    = active && (eff_wr || !legal);
    assign ready       = active && legal && (cnt_q == CNT_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_int  <= INT_W'(1);
            div_frac <= '0;
        end else if (eff_wr) begin
            div_int  <= wr_int;
            div_frac <= wr_frac;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active || eff_wr || !legal)
            cnt_q <= '0;
        else if (cnt_q != CNT_DONE)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)            loss <= 1'b0;
        else if (loss_set)  loss <= 1'b1;
        else if (loss_clr)  loss <= 1'b0;
    end

    // R6
    loss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        loss && !loss_clr |=> loss);

    // R8
    bad_div_chk: assert property (@(posedge clk) disable iff (rst)
        active && !legal |=> loss && !ready);

    // R7
    rewrite_lol_chk: assert property (@(posedge clk) disable iff (rst)
        active && div_wr && !same_val |=> loss && !ready);

    // R9
    same_write_noop_chk: assert property (@(posedge clk) disable iff (rst)
        ready && !loss && div_wr && same_val |=> ready && !loss);

endmodule

// File: rtl/fdiv_readback.sv
module fdiv_readback
    import fdiv_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int INT_W     = 8,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 14
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             glob_hold,
    input  logic [NUM_PORTS-1:0]             port_hold,
    input  logic [NUM_PORTS-1:0]             ready,
    input  logic [NUM_PORTS-1:0]             loss,
    input  logic [NUM_PORTS-1:0][INT_W-1:0]  div_int,
    input  logic [NUM_PORTS-1:0][FRAC_W-1:0] div_frac,
    output logic [DATA_W-1:0]                rdata
);

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL))       rdata[0] = glob_hold;
        else if (addr == ADDR_W'(ADDR_HOLD))  rdata[NUM_PORTS-1:0] = port_hold;
        else if (addr == ADDR_W'(ADDR_READY)) rdata[NUM_PORTS-1:0] = ready;
        else if (addr == ADDR_W'(ADDR_LOSS))  rdata[NUM_PORTS-1:0] = loss;
        else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (addr == ADDR_W'(ADDR_DIV0 + p)) begin
                    rdata[FRAC_W-1:0]         = div_frac[p];
                    rdata[FRAC_W +: INT_W]    = div_int[p];
                end
            end
        end
    end

endmodule

// File: rtl/fdiv_port_ctrl.sv
module fdiv_port_ctrl
    import fdiv_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int INT_W       = 8,
    parameter int LOCK_CYCLES = 16,
    parameter int ADDR_W      = 4,
    localparam int DATA_W     = FRAC_W + INT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_PORTS-1:0] port_ready,
    output logic [NUM_PORTS-1:0] port_lol
);

    logic                             glob_hold;
    logic [NUM_PORTS-1:0]             port_hold;
    logic                             ctrl_wr, hold_wr, loss_wr;
    logic [NUM_PORTS-1:0][INT_W-1:0]  div_int;
    logic [NUM_PORTS-1:0][FRAC_W-1:0] div_frac;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign hold_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_HOLD));
    assign loss_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_LOSS));

    fdiv_global_regs #(.NUM_PORTS(NUM_PORTS)) i_glob (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .hold_wr   (hold_wr),
        .ctrl_bit  (bus_wdata[0]),
        .hold_bits (bus_wdata[NUM_PORTS-1:0]),
        .glob_hold (glob_hold),
        .port_hold (port_hold)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic div_wr_p;
        assign div_wr_p = bus_wr && (bus_addr == ADDR_W'(ADDR_DIV0 + p));

        fdiv_port_unit #(.INT_W(INT_W), .LOCK_CYCLES(LOCK_CYCLES)) i_port (
            .clk       (clk),
            .rst       (rst),
            .glob_hold (glob_hold),
            .port_hold (port_hold[p]),
            .div_wr    (div_wr_p),
            .wr_int    (bus_wdata[FRAC_W +: INT_W]),
            .wr_frac   (bus_wdata[FRAC_W-1:0]),
            .loss_clr  (loss_wr && bus_wdata[p]),
            .div_int   (div_int[p]),
            .div_frac  (div_frac[p]),
            .ready     (port_ready[p]),
            .loss      (port_lol[p])
        );
    end

    fdiv_readback #(
        .NUM_PORTS (NUM_PORTS),
        .INT_W     (INT_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) i_rb (
        .addr      (bus_addr),
        .glob_hold (glob_hold),
        .port_hold (port_hold),
        .ready     (port_ready),
        .loss      (port_lol),
        .div_int   (div_int),
        .div_frac  (div_frac),
        .rdata     (bus_rdata)
    );

    // R2
    glob_gates_ready_chk: assert property (@(posedge clk) disable iff (rst)
        glob_hold |-> port_ready == '0);

endmodule

// File: tb/test_fdiv_port_ctrl.sv
module test_fdiv_port_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int IW    = 8;
    localparam int LOCK  = 16;
    localparam int AW    = 4;
    localparam int DW    = 6 + IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  port_ready, port_lol;

    int checks = 0;
    int errors = 0;

    // {legal, integer[7:0], fraction[5:0]}
    localparam logic [14:0] VEC [6] = '{
        {1'b1, 8'd1,   6'd0},
        {1'b0, 8'd0,   6'd0},
        {1'b1, 8'd255, 6'd35},
        {1'b0, 8'd3,   6'd36},
        {1'b0, 8'd0,   6'd35},
        {1'b1, 8'd5,   6'd17}
    };

    fdiv_port_ctrl #(.NUM_PORTS(N), .INT_W(IW), .LOCK_CYCLES(LOCK), .ADDR_W(AW)) i_fdiv_port_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_ready(port_ready), .port_lol(port_lol)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    function automatic logic [DW-1:0] dword(input int i, input int f);
        return {IW'(i), 6'(f)};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] d;
        wait_cyc(3);
        rst = 1'b0;

        // R1: reset state and map
        rd(0, d); chk("R1 ctrl", d, 1);
        rd(1, d); chk("R1 hold", d, 4'hF);
        rd(2, d); chk("R1 ready", d, 0);
        rd(3, d); chk("R1 loss", d, 0);
        rd(4, d); chk("R1 div", d, dword(1, 0));

        // R2: ports released but global hold set
        wr(1, 0);
        wait_cyc(LOCK + 4);
        chk("R2 ready under global hold", port_ready, 0);
        rd(2, d); chk("R2 ready reg", d, 0);

        // R10: program under global hold, read back, no loss
        wr(4, dword(10, 0));
        wr(5, dword(4, 18));
        wr(6, dword(1, 35));
        wr(7, dword(7, 9));
        rd(5, d); chk("R10 readback", d, dword(4, 18));
        chk("R10 no loss when held", port_lol, 0);

        // R3: exact lock latency
        wr(0, 0);
        wait_cyc(LOCK - 1);
        chk("R3 not yet ready", port_ready, 0);
        wait_cyc(1);
        chk("R3 ready", port_ready, 4'hF);

        // R9: same-value rewrite
        wr(5, dword(4, 18));
        chk("R9 ready kept", port_ready, 4'hF);
        chk("R9 no loss", port_lol, 0);

        // R7: different value on running port
        wr(7, dword(7, 10));
        chk("R7 ready drop", port_ready, 4'b0111);
        chk("R7 loss set", port_lol, 4'b1000);
        wait_cyc(3);
        chk("R6 sticky", port_lol, 4'b1000);
        wait_cyc(LOCK - 4);
        chk("R7 relock not early", port_ready, 4'b0111);
        wait_cyc(1);
        chk("R7 relocked", port_ready, 4'hF);
        chk("R6 sticky after relock", port_lol, 4'b1000);

        // R5: selective clear
        wr(4, dword(11, 0));
        chk("R5 two flags", port_lol, 4'b1001);
        wr(3, 4'b0001);
        chk("R5 masked clear", port_lol, 4'b1000);
        wr(3, 4'b1000);
        chk("R5 clear rest", port_lol, 0);
        wait_cyc(LOCK);
        chk("R5 all ready", port_ready, 4'hF);

        // R4: single port hold
        wr(1, 4'b0010);
        chk("R4 port1 held", port_ready, 4'b1101);
        wr(1, 0);
        wait_cyc(LOCK);
        chk("R4 released", port_ready, 4'hF);

        // R8 / R10: table walk on port 2
        for (int v = 0; v < 6; v++) begin
            logic legal;
            logic [DW-1:0] w;
            legal = VEC[v][14];
            w = VEC[v][13:0];
            wr(1, 4'b0100);
            wr(3, 4'b0100);
            wr(6, w);
            rd(6, d); chk("R10 table readback", d, w);
            chk("R10 table no loss held", port_lol[2], 0);
            wr(1, 0);
            wait_cyc(LOCK + 2);
            chk("R8 table ready", port_ready[2], legal);
            chk("R8 table loss", port_lol[2], !legal);
            chk("R4 table others", port_ready[1:0], 2'b11);
        end

        // R2: global hold masks everything at once
        wr(0, 1);
        chk("R2 global hold drop", port_ready, 0);
        rd(2, d); chk("R2 ready reg after hold", d, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule